// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block sits inside a memory controller and decides, one row at a time, whether a DRAM row has to be refreshed in the current pass. It keeps a row pointer that sweeps all rows. Each row is classed by how long its cells hold their charge. A row with weak cells goes in the fast bin and is refreshed on every sweep. A row in the middle bin is refreshed on every second sweep. Every other row falls in the default bin and is refreshed on every fourth sweep. So a sweep lasts one quarter of the longest refresh period, and the base period of 64 ms per row is kept for the weakest rows.

Bin membership is held in two small Bloom filters, one for the fast bin and one for the middle bin. Software loads them row by row through an insert port while scheduling is turned off. It can also wipe them with a clear strobe. A Bloom filter can report a row that was never inserted, but it never misses one that was. The only cost of such a false hit is an extra refresh.

A due row leaves as a request carrying its row address on a valid/ready port. A row that is not due is skipped and counted, and no request is made for it.

Top module: `rr_refresh_sched`

## Requirements
- R1: After synchronous reset, req_valid is low and skip_count is zero. The row pointer and the 2-bit sweep counter are both zero, so the first row considered is row 0 in sweep 0.
- R2: Row index hashing works on a row address r of ROW_W bits, a filter index width IDX_W and three hashes j = 0, 1, 2. Hash j rotates r left by j places within ROW_W bits, then XORs the result together in IDX_W-bit slices starting at bit 0, with the top slice zero-padded.
- R3: An insert sets the three hashed bits in one filter: ins_bin 0 selects the fast filter and ins_bin 1 the middle filter. A row is a member of a filter when all three of its hashed bits are set, so an inserted row is never missed.
- R4: Bin priority: a row found in the fast filter is in the fast bin, even if it is also in the middle filter. Otherwise a row found in the middle filter is in the middle bin. Otherwise the row is in the default bin.
- R5: The sweep counter starts at 0 and adds one (modulo 4) each time the row pointer wraps from the last row back to row 0. Which rows are due:
  - a fast-bin row is due on every sweep;
  - a middle-bin row is due when the sweep counter is even;
  - a default-bin row is due only when the sweep counter is 0.
- R6: A row that is not due takes one cycle. In that cycle no request is made, skip_count rises by one (holding at its maximum value) and the pointer moves to the next row.
- R7: A due row raises req_valid with req_row set to that row. Both stay unchanged until req_ready is seen high. The pointer moves on only in the cycle the request is accepted.
- R8: While sched_en is high, ins_valid and flt_clear have no effect on either filter.
- R9: While sched_en is low, flt_clear sets every bit of both filters to zero, so every row falls in the default bin.
- R10: While sched_en is low:
  - no new request is raised;
  - skip_count, the row pointer and the sweep counter hold their values;
  - a request that is already pending stays until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_en | input | 1 | Enables the row sweep; while it is low the filters may be written |
| flt_clear | input | 1 | Zeroes both filters (only acted on while sched_en is low) |
| ins_valid | input | 1 | Insert strobe for one row into one filter |
| ins_bin | input | 1 | Target filter for the insert: 0 fast, 1 middle |
| ins_row | input | ROW_W | Row address to insert |
| req_ready | input | 1 | Downstream accepts the pending refresh request |
| req_valid | output | 1 | A refresh request is pending |
| req_row | output | ROW_W | Row address of the pending request |
| skip_count | output | SKIP_W | Saturating count of rows skipped as not due |

## Verification
A wrong filter bit, or a hash that differs from the stated formula, first shows up in the sweep where that row's bin matters: the row is skipped or requested on the wrong sweep. The bench sees this as a wrong req_row on the next request. It also sees a skip_count that is off by the number of rows that were wrongly classed. A sweep counter or pointer that slips makes the very next request carry the wrong row address, so a broken wrap is caught within one sweep of 64 rows. A handshake fault, such as dropping a held request or moving on without acceptance, shows at the next falling edge as a changed req_row or a missing request.

// File: rtl/rr_refresh_pkg.sv
`timescale 1ns/1ps
package rr_refresh_pkg;
  // Number of short-retention bins backed by a filter (fast, middle).
  localparam int NUM_FLT = 2;
  // Sweep counter width: the slowest bin is refreshed every 2**IVL_W sweeps.
  localparam int IVL_W   = 2;

  typedef enum logic [1:0] {
    BIN_FAST = 2'd0,
    BIN_MID  = 2'd1,
    BIN_SLOW = 2'd2
  } rbin_e;

  // Fast bin wins over middle bin, which wins over the default bin.
  function automatic rbin_e pick_bin(input logic fast_hit, input logic mid_hit);
    if (fast_hit)     return BIN_FAST;
    else if (mid_hit) return BIN_MID;
    else              return BIN_SLOW;
  endfunction

  function automatic logic bin_due(input rbin_e b, input logic [IVL_W-1:0] ivl);
    case (b)
      BIN_FAST: return 1'b1;
      BIN_MID:  return ~ivl[0];
      default:  return (ivl == '0);
    endcase
  endfunction
endpackage

// File: rtl/rr_row_hash.sv
`timescale 1ns/1ps
// Produces K filter indices from one row address: rotate by j, then XOR-fold.
module rr_row_hash #(
  parameter int ROW_W = 6,
  parameter int IDX_W = 5,
  parameter int K     = 3
) (
  input  logic [ROW_W-1:0]          key,
  output logic [K-1:0][IDX_W-1:0]   idx
);
  for (genvar j = 0; j < K; j++) begin : g_hash
    localparam int SH = j % ROW_W;
    logic [ROW_W-1:0] rot;
    assign rot = (key << SH) | (key >> (ROW_W - SH));
    always_comb begin
      idx[j] = '0;
      for (int b = 0; b < ROW_W; b++) begin
        idx[j][b % IDX_W] = idx[j][b % IDX_W] ^ rot[b];
      end
    end
  end
endmodule

// File: rtl/rr_bloom_bank.sv
`timescale 1ns/1ps
// One Bloom filter: K-bit set on insert, K-bit AND on lookup, whole-array clear.
module rr_bloom_bank #(
  parameter int IDX_W = 5,
  parameter int K     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    wr,
  input  logic [K-1:0][IDX_W-1:0] idx,
  output logic                    hit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bits_q <= '0;
    end else if (wr) begin
      for (int j = 0; j < K; j++) begin
        bits_q[idx[j]] <= 1'b1;
      end
    end
  end

  always_comb begin
    hit = 1'b1;
    for (int j = 0; j < K; j++) begin
      hit = hit & bits_q[idx[j]];
    end
  end
endmodule

// File: rtl/rr_row_sweep.sv
`timescale 1ns/1ps
// Row pointer, sweep counter, skip/issue decision, request register, skip counter.
module rr_row_sweep
  import rr_refresh_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              fast_hit,
  input  logic              mid_hit,
  input  logic              req_ready,
  output logic [ROW_W-1:0]  cur_row,
  output logic              req_valid,
  output logic [ROW_W-1:0]  req_row,
  output logic [SKIP_W-1:0] skip_count
);
  localparam logic [ROW_W-1:0]  ROW_LAST = '1;
  localparam logic [SKIP_W-1:0] SKIP_MAX = '1;

  logic [IVL_W-1:0] ivl_q;
  rbin_e            bin;
  logic             due;
  logic             eval;
  logic             accept;
  logic             advance;

  assign bin     = pick_bin(fast_hit, mid_hit);
  assign due     = bin_due(bin, ivl_q);
  assign eval    = enable & ~req_valid;
  assign accept  = req_valid & req_ready;
  assign advance = (eval & ~due) | accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_row    <= '0;
      ivl_q      <= '0;
      req_valid  <= 1'b0;
      req_row    <= '0;
      skip_count <= '0;
    end else begin
      if (advance) begin
        cur_row <= cur_row + 1'b1;
        if (cur_row == ROW_LAST) ivl_q <= ivl_q + 1'b1;
      end
      if (eval && due) begin
        req_valid <= 1'b1;
        req_row   <= cur_row;
      end else if (accept) begin
        req_valid <= 1'b0;
      end
      if (eval && !due && skip_count != SKIP_MAX) begin
        skip_count <= skip_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_refresh_sched.sv
`timescale 1ns/1ps
module rr_refresh_sched
  import rr_refresh_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int IDX_W  = 5,
  parameter int K      = 3,
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sched_en,
  input  logic              flt_clear,
  input  logic              ins_valid,
  input  logic              ins_bin,
  input  logic [ROW_W-1:0]  ins_row,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ROW_W-1:0]  req_row,
  output logic [SKIP_W-1:0] skip_count
);
  logic [ROW_W-1:0]        cur_row;
  logic [ROW_W-1:0]        key;
  logic [K-1:0][IDX_W-1:0] idx;
  logic [NUM_FLT-1:0]      flt_hit;
  logic                    fast_hit;
  logic                    mid_hit;
  logic                    ins_fire;
  logic                    clr_fire;

  // One hash unit serves both phases: insert row while idle, sweep row while running.
  assign key      = sched_en ? cur_row : ins_row;
  assign ins_fire = ins_valid & ~sched_en;
  assign clr_fire = flt_clear & ~sched_en;

  rr_row_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W), .K(K)) hash_i (
    .key (key),
    .idx (idx)
  );

  for (genvar b = 0; b < NUM_FLT; b++) begin : g_flt
    logic sel;
    assign sel = (ins_bin == b[0]);
    rr_bloom_bank #(.IDX_W(IDX_W), .K(K)) bank_i (
      .clk (clk),
      .rst (rst),
      .clr (clr_fire),
      .wr  (ins_fire & sel),
      .idx (idx),
      .hit (flt_hit[b])
    );
  end

  assign fast_hit = flt_hit[0];
  assign mid_hit  = flt_hit[1];

  rr_row_sweep #(.ROW_W(ROW_W), .SKIP_W(SKIP_W)) sweep_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (sched_en),
    .fast_hit   (fast_hit),
    .mid_hit    (mid_hit),
    .req_ready  (req_ready),
    .cur_row    (cur_row),
    .req_valid  (req_valid),
    .req_row    (req_row),
    .skip_count (skip_count)
  );
endmodule

// File: rtl/rr_refresh_chk.sv
`timescale 1ns/1ps
module rr_refresh_chk #(
  parameter int ROW_W  = 6,
  parameter int SKIP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sched_en,
  input logic              fast_hit,
  input logic              req_ready,
  input logic              req_valid,
  input logic [ROW_W-1:0]  req_row,
  input logic [SKIP_W-1:0] skip_count
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row))); // R7

  AST_SKIP_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (skip_count == $past(skip_count) || skip_count == $past(skip_count) + 1'b1)); // R6

  AST_FAST_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
    (sched_en && !req_valid && fast_hit) |=> (req_valid && $stable(skip_count))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sched_en |=> $stable(skip_count)); // R10

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (!sched_en && !req_valid) |=> !req_valid); // R10
endmodule

bind rr_refresh_sched rr_refresh_chk #(.ROW_W(ROW_W), .SKIP_W(SKIP_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .sched_en   (sched_en),
  .fast_hit   (fast_hit),
  .req_ready  (req_ready),
  .req_valid  (req_valid),
  .req_row    (req_row),
  .skip_count (skip_count)
);

// File: tb/rr_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module rr_refresh_sched_tb_top;
  localparam int ROW_W  = 6;
  localparam int IDX_W  = 5;
  localparam int K      = 3;
  localparam int SKIP_W = 16;
  localparam int NROWS  = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sched_en = 1'b0;
  logic              flt_clear = 1'b0;
  logic              ins_valid = 1'b0;
  logic              ins_bin = 1'b0;
  logic [ROW_W-1:0]  ins_row = '0;
  logic              req_ready = 1'b0;
  logic              req_valid;
  logic [ROW_W-1:0]  req_row;
  logic [SKIP_W-1:0] skip_count;

  always #2.5 clk = ~clk;

  rr_refresh_sched #(.ROW_W(ROW_W), .IDX_W(IDX_W), .K(K), .SKIP_W(SKIP_W)) dut_i (
    .clk(clk), .rst(rst), .sched_en(sched_en), .flt_clear(flt_clear),
    .ins_valid(ins_valid), .ins_bin(ins_bin), .ins_row(ins_row),
    .req_ready(req_ready), .req_valid(req_valid), .req_row(req_row),
    .skip_count(skip_count)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  bit  mf [2][32];
  int  mrow = 0, mivl = 0, mskip = 0;
  bit  pend = 0;
  int  cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2 hash, written arithmetically for the 6-bit row / 5-bit index setup.
  function automatic int hsh(input int r, input int j);
    int rot;
    rot = ((r << j) | (r >> (6 - j))) & 63;
    return (rot & 31) ^ (rot >> 5);
  endfunction

  function automatic bit member(input int b, input int r);
    return mf[b][hsh(r,0)] && mf[b][hsh(r,1)] && mf[b][hsh(r,2)];
  endfunction

  function automatic bit mdue(input int r);
    if (member(0, r)) return 1;
    if (member(1, r)) return (mivl % 2) == 0;
    return mivl == 0;
  endfunction

  task automatic madv();
    mrow = (mrow + 1) % NROWS;
    if (mrow == 0) mivl = (mivl + 1) % 4;
  endtask

  // Request monitor: every new request must be the next due row of the model.
  always @(negedge clk) begin
    if (!rst && req_valid) begin
      if (!pend) begin
        for (int g = 0; g < 4 * NROWS && !mdue(mrow); g++) begin
          mskip++;
          madv();
        end
        chk(req_row == mrow, "R3 R4 R5 next row", req_row, mrow);
        chk(skip_count == mskip, "R6 skip count", skip_count, mskip);
        pend = 1;
      end else begin
        chk(req_row == mrow, "R7 held row", req_row, mrow);
      end
      if (req_ready) begin
        madv();
        pend = 0;
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_ins(input bit b, input int r, input bit model);
    step();
    ins_valid = 1'b1; ins_bin = b; ins_row = r[ROW_W-1:0];
    step();
    ins_valid = 1'b0;
    if (model) for (int j = 0; j < 3; j++) mf[b][hsh(r, j)] = 1;
  endtask

  task automatic do_clr(input bit model);
    step();
    flt_clear = 1'b1;
    step();
    flt_clear = 1'b0;
    if (model) for (int b = 0; b < 2; b++) for (int i = 0; i < 32; i++) mf[b][i] = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      cyc++;
      req_ready = ((cyc % 5) != 1) && ((cyc % 7) != 3);
    end
  endtask

  task automatic go_idle();
    step();
    sched_en = 1'b0; req_ready = 1'b1;
    repeat (3) step();
  endtask

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 32; i++) mf[b][i] = 0;
    repeat (4) step();
    rst = 1'b0;
    step();
    chk(req_valid == 1'b0, "R1 req_valid after reset", req_valid, 0);
    chk(skip_count == 0, "R1 skip_count after reset", skip_count, 0);

    // Load filters while idle (R3); row 17 is in both bins (R4 priority).
    do_ins(0, 3, 1);  do_ins(0, 17, 1); do_ins(0, 40, 1);
    do_ins(1, 5, 1);  do_ins(1, 17, 1); do_ins(1, 22, 1); do_ins(1, 63, 1);
    step(); sched_en = 1'b1;
    run(1500);

    // R8: insert and clear while running must change nothing.
    do_ins(0, 9, 0);
    do_clr(0);
    run(1500);

    // R10: pause; pending request drains, then nothing moves.
    begin
      logic [SKIP_W-1:0] s0;
      go_idle();
      s0 = skip_count;
      for (int i = 0; i < 15; i++) begin
        step();
        chk(req_valid == 1'b0, "R10 no request while idle", req_valid, 0);
        chk(skip_count == s0, "R10 skip held while idle", skip_count, s0);
      end
    end
    step(); sched_en = 1'b1;
    run(600);

    // R9: clear while idle, reload middle bin only.
    go_idle();
    do_clr(1);
    do_ins(1, 1, 1); do_ins(1, 2, 1);
    step(); sched_en = 1'b1;
    run(1500);

    go_idle();
    chk(n_chk > 100, "R6 enough requests observed", n_chk, 100);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule